// File: doc/BRIEF.md
# Input-Toggled Cyclic Shift Register

This block is a four-bit ring of flip-flops that moves its contents one place toward the tail on every enabled clock edge. The bit that leaves the tail returns to the head, but first it is XORed with a one-bit serial input. The input can therefore flip the recirculating value. When the input stays low, the ring is a plain rotation.

The serial output is the current tail bit. It is combinational from the stored state, so it always shows the value from before the edge that consumes the present input. A synchronous load port writes a full starting pattern. A synchronous reset clears the ring. The whole state is also visible on a debug port.

Each cycle, exactly one action happens. The actions in priority order are load, then clear, then shift, then hold.

Top module: `tgs_shift_top`

## Requirements
- R1: While `rst` is high and `load_en` is low at a rising edge, every bit of the state becomes 0 after that edge.
- R2: While `load_en` is high at a rising edge, the state becomes `load_val` after that edge. This holds regardless of `rst`, `shift_en` and `tgl_in`. `load_val` bit i lands in state bit i.
- R3: On a shifting edge, the new head bit (state bit 0) equals the old tail bit (state bit 3) XOR `tgl_in`. A shifting edge is one where `load_en` and `rst` are low and `shift_en` is high.
- R4: On a shifting edge, each old state bit i (for i from 0 to 2) moves to state bit i+1, and the old tail value leaves position 3.
- R5: On shifting edges with `tgl_in` low, the state rotates cyclically, so a pattern returns to itself after exactly four shifts.
- R6: When `shift_en`, `load_en` and `rst` are all low at an edge, the state does not change.
- R7: `ser_out` always equals state bit 3, the tail. A change on `tgl_in` between edges leaves `ser_out` unchanged until the next edge.
- R8: The state is exactly four bits wide, and `state_view` shows all of it, with bit 0 as the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous clear, active high, yields to load |
| load_en | input | 1 | Synchronous load strobe, highest priority |
| load_val | input | 4 | Pattern written by a load |
| shift_en | input | 1 | Advances the ring when high |
| tgl_in | input | 1 | Serial toggle bit XORed into the wrapped tail |
| ser_out | output | 1 | Current tail bit |
| state_view | output | 4 | Debug view of the whole ring, bit 0 = head |

## Verification
Load, clear, shift and hold all show on `state_view` one rising edge after the inputs that cause them. The bench drives inputs on the falling edge and compares against its own model on the following falling edge, after exactly one rising edge. The tail output has no latency of its own. It is checked twice in each cycle: once just after new inputs are applied, to confirm it still shows the pre-edge state, and again after the edge. The assertions take the same one-edge view, using `|=>` and `$past` of depth one.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

  // One action per edge, resolved by fixed priority.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_LOAD  = 2'd3
  } tgs_act_e;

  // Priority: load over clear over shift over hold.
  function automatic tgs_act_e pick_action(input logic ld, input logic clr,
                                           input logic en);
    if (ld)       return ACT_LOAD;
    else if (clr) return ACT_CLEAR;
    else if (en)  return ACT_SHIFT;
    else          return ACT_HOLD;
  endfunction

  // Value entering the head: wrapped tail flipped by the serial input.
  function automatic logic wrap_bit(input logic tail, input logic tgl);
    return tail ^ tgl;
  endfunction

endpackage

// File: rtl/tgs_ctrl.sv
module tgs_ctrl
  import tgs_pkg::*;
(
  input  logic     load_en,
  input  logic     rst,
  input  logic     shift_en,
  output tgs_act_e act,
  output logic     fire_shift
);
  assign act        = pick_action(load_en, rst, shift_en);
  assign fire_shift = (act == ACT_SHIFT);
endmodule

// File: rtl/tgs_feedback.sv
module tgs_feedback
  import tgs_pkg::*;
(
  input  logic tail,
  input  logic tgl_in,
  output logic head_nxt
);
  assign head_nxt = wrap_bit(tail, tgl_in);
endmodule

// File: rtl/tgs_cell.sv
module tgs_cell
  import tgs_pkg::*;
(
  input  logic     clk,
  input  tgs_act_e act,
  input  logic     load_bit,
  input  logic     shift_bit,
  output logic     q
);
  always_ff @(posedge clk) begin
    unique case (act)
      ACT_LOAD:  q <= load_bit;
      ACT_CLEAR: q <= 1'b0;
      ACT_SHIFT: q <= shift_bit;
      default:   q <= q;
    endcase
  end
endmodule

// File: rtl/tgs_shift_top.sv
module tgs_shift_top
  import tgs_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift_en,
  input  logic             tgl_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] state_view
);
  localparam int TAIL = WIDTH - 1;

  tgs_act_e         act;
  logic             fire_shift;
  logic             head_nxt;
  logic [WIDTH-1:0] ring_q;
  logic [WIDTH-1:0] shift_src;

  tgs_ctrl u_ctrl (
    .load_en    (load_en),
    .rst        (rst),
    .shift_en   (shift_en),
    .act        (act),
    .fire_shift (fire_shift)
  );

  tgs_feedback u_fb (
    .tail     (ring_q[TAIL]),
    .tgl_in   (tgl_in),
    .head_nxt (head_nxt)
  );

  // Source of each cell on a shift: head takes feedback, others their lower neighbour.
  assign shift_src[0] = head_nxt;
  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_src
      assign shift_src[i] = ring_q[i-1];
    end
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      tgs_cell u_cell (
        .clk       (clk),
        .act       (act),
        .load_bit  (load_val[i]),
        .shift_bit (shift_src[i]),
        .q         (ring_q[i])
      );
    end
  endgenerate

  assign ser_out    = ring_q[TAIL];
  assign state_view = ring_q;
endmodule

// File: rtl/tgs_checker.sv
module tgs_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         load_en,
  input logic [W-1:0] load_val,
  input logic         shift_en,
  input logic         tgl_in,
  input logic         ser_out,
  input logic [W-1:0] state_view,
  input logic         fire_shift
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
    (rst === 1'b1 && load_en === 1'b0) |=> (state_view == '0));

  // R2
  a_r2_load_wins: assert property (@(posedge clk) disable iff (!armed)
    (load_en === 1'b1) |=> (state_view == $past(load_val)));

  // R3
  a_r3_head_toggle: assert property (@(posedge clk) disable iff (rst || !armed)
    (fire_shift === 1'b1) |=> (state_view[0] == ($past(state_view[W-1]) ^ $past(tgl_in))));

  // R4
  a_r4_move_to_tail: assert property (@(posedge clk) disable iff (rst || !armed)
    (fire_shift === 1'b1) |=> (state_view[W-1:1] == $past(state_view[W-2:0])));

  // R5
  a_r5_plain_rotate: assert property (@(posedge clk) disable iff (rst || !armed)
    (fire_shift === 1'b1 && tgl_in === 1'b0) |=>
      (state_view == {$past(state_view[W-2:0]), $past(state_view[W-1])}));

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    (shift_en === 1'b0 && load_en === 1'b0) |=> $stable(state_view));

  // R7
  a_r7_tail_out: assert property (@(posedge clk) disable iff (rst || !armed)
    (fire_shift === 1'b1) |=> (ser_out == $past(state_view[W-2])));
endmodule

bind tgs_shift_top tgs_checker #(.W(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_en    (load_en),
  .load_val   (load_val),
  .shift_en   (shift_en),
  .tgl_in     (tgl_in),
  .ser_out    (ser_out),
  .state_view (state_view),
  .fire_shift (fire_shift)
);

// File: tb/tb_tgs_shift_top.sv
module tb_tgs_shift_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       load_en;
  logic [3:0] load_val;
  logic       shift_en;
  logic       tgl_in;
  logic       ser_out;
  logic [3:0] state_view;

  int n_checks = 0;
  int n_fail   = 0;
  int model    = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgs_shift_top dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .shift_en(shift_en), .tgl_in(tgl_in), .ser_out(ser_out),
    .state_view(state_view)
  );

  // Reference step written as integer arithmetic.
  function automatic int ref_next(int s, bit ld, int lv, bit rs, bit en, bit t);
    if (ld) return lv & 15;
    if (rs) return 0;
    if (!en) return s;
    return ((s * 2) % 16) + (((s / 8) % 2) ^ t);
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at falling edge, verify ser_out unchanged, then check after one rising edge.
  task automatic step(bit ld, int lv, bit rs, bit en, bit t, string req);
    int held_tail;
    held_tail = (model / 8) % 2;
    load_en = ld; load_val = lv[3:0]; rst = rs; shift_en = en; tgl_in = t;
    #1;
    check("R7 pre-edge tail", int'(ser_out), held_tail);
    model = ref_next(model, ld, lv, rs, en, t);
    @(negedge clk);
    check(req, int'(state_view), model);
    check("R7 tail", int'(ser_out), (model / 8) % 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    rst = 1'b1; load_en = 1'b0; load_val = 4'h0; shift_en = 1'b0; tgl_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model = 0;
    check("R1 reset state", int'(state_view), 0);
    check("R8 width", $bits(state_view), 4);

    // R2: load beats reset and enable
    step(1, 4'b1000, 1, 1, 1, "R2 load over reset");
    // R5: four plain rotations return the pattern
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, "R5 rotate");
    check("R5 back to start", int'(state_view), 8);
    // R3: toggle flips wrapped tail
    step(0, 0, 0, 1, 1, "R3 toggle head");
    step(0, 0, 0, 1, 1, "R3 toggle zero tail");
    // R4: bits march toward tail
    step(1, 4'b0011, 0, 0, 0, "R2 load");
    step(0, 0, 0, 1, 0, "R4 shift");
    step(0, 0, 0, 1, 0, "R4 shift");
    // R6: hold with toggle active
    step(0, 0, 0, 0, 1, "R6 hold");
    step(0, 0, 0, 0, 1, "R6 hold");
    // R1: clear beats enable
    step(0, 0, 1, 1, 1, "R1 clear");

    seed = $urandom(32'd1234);
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom;
      step((r % 13) == 0, $urandom % 16, (r % 29) == 1, (r % 4) != 0,
           (($urandom % 3) == 0), "R3/R4/R6 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule